// File: doc/BRIEF.md
# Alternating-Clock Two-Wire Serial Receiver

This block receives frames from a two-wire serial bus on which the two lines take turns as clock and data. Both lines idle high. A falling edge on either line marks a valid bit on the other line, so the receiver only has to classify falling edges. It does not track bus phases beyond remembering which line clocked the most recent slot. Both lines are sampled with the system clock, passed through two-flop synchronisers, and then passed through a persistence filter before any edge is detected.

A frame begins with a start pattern: line A is held low while line B falls four times. The receiver then collects bits MSB first and packs them into bytes. It rebuilds 32-bit words from groups of four bytes that arrive last-byte-first, and presents each word for one cycle on a valid strobe. The expected word count is taken from an input while the receiver is waiting for a start pattern. The byte after the last word is an XOR checksum. A frame ends when two slots in a row are both clocked by line A. At that point the receiver pulses frame-done, together with a checksum-error flag if the checksum did not match. A stop pattern that comes too early, surplus bytes, or a silent bus in mid-frame each raise a one-cycle framing-error pulse, and the receiver goes back to hunting for a start pattern.

Top module: `ac2w_rx`

## Requirements
- R1: After reset, word_valid_o, frame_done_o, chk_err_o and frame_err_o are all low, and the receiver is hunting for a start pattern.
- R2: A frame starts only after four falling edges on line B while line A stays low. Three such edges followed by a complete frame give no word and no frame-done.
- R3: A falling edge on line A samples line B, and a falling edge on line B samples line A. Within a byte, the first bit received is bit 7.
- R4: Received bytes r0, r1, r2, r3 of each word (r0 first) are output as word_data_o = {r3, r2, r1, r0}, with a one-cycle word_valid_o, once the fourth byte completes.
- R5: If the byte that follows the expected 4×word_count_i data bytes equals the XOR of those data bytes, the stop pattern gives a frame_done_o pulse with chk_err_o low.
- R6: If that checksum byte differs from the XOR, frame_done_o pulses together with chk_err_o. chk_err_o is never high without frame_done_o.
- R7: An A-clocked slot that directly follows another A-clocked slot is the stop pattern. A B-clocked slot that directly follows another B-clocked slot (the tail of the start pattern and the head of the stop pattern) carries no bit. After frame-done the receiver is hunting again.
- R8: A stop pattern that arrives before the checksum byte gives a frame_err_o pulse and no frame_done_o. Words already completed are still output.
- R9: A byte that arrives after the checksum byte gives a frame_err_o pulse, returns the receiver to hunting, and outputs no word beyond word_count_i.
- R10: If there is no falling edge on either line for TMO_CYC cycles in mid-frame, frame_err_o pulses and the receiver returns to hunting. The next valid frame is then received normally.
- R11: A level change that lasts fewer than FILT_LEN system cycles after synchronisation is ignored and does not disturb the frame.
- R12: With word_count_i = 0, a frame made of the checksum byte 0x00 and a stop pattern gives frame_done_o with chk_err_o low and no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8× the slot rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_a_i | input | 1 | Bus line A (asynchronous) |
| line_b_i | input | 1 | Bus line B (asynchronous) |
| word_count_i | input | WCW | Number of 32-bit words expected in the next frame |
| word_valid_o | output | 1 | One-cycle strobe: word_data_o holds a completed word |
| word_data_o | output | 32 | Reassembled word, with byte order restored |
| frame_done_o | output | 1 | One-cycle pulse when a stop pattern follows the checksum |
| chk_err_o | output | 1 | Checksum mismatch, valid together with frame_done_o |
| frame_err_o | output | 1 | One-cycle pulse on a framing error or timeout |

## Verification
A wrong remembered slot type shows up at once: it either drops a bit, so that every later word is shifted and the scoreboard mismatches within one word, or it ends the frame early with a framing error. A wrong byte counter or wrong expected count shows up at the end of the frame, as a missing or extra frame-done, as a framing error, or as a checksum flag on a good frame. Filter or synchroniser faults either let the injected glitch turn into a bit, which corrupts the word under test, or delay edges unevenly so that the sampled data no longer matches.

// File: rtl/ac2w_pkg.sv
package ac2w_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RX   = 1'b1
  } rx_state_e;

  // Bytes arrive last-of-word first: each new byte enters at the top
  // and the earlier ones move down one lane.
  function automatic logic [31:0] push_byte(input logic [31:0] word,
                                            input logic [7:0]  b);
    return {b, word[31:8]};
  endfunction

  // A byte is complete when the bit count is about to wrap.
  function automatic logic byte_last_bit(input logic [2:0] bit_cnt);
    return bit_cnt == 3'd7;
  endfunction

endpackage

// File: rtl/ac2w_line_cond.sv
module ac2w_line_cond #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic          filt_q;
  logic          prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      prev_q <= filt_q;
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = filt_q;
  assign fall_o  = prev_q & ~filt_q;

  // The filtered line needs a rise between two falls.
  AST_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);  // R11

endmodule

// File: rtl/ac2w_frame_fsm.sv
module ac2w_frame_fsm
  import ac2w_pkg::*;
#(
  parameter int WCW     = 8,
  parameter int TMO_CYC = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fall_a_i,
  input  logic           fall_b_i,
  input  logic           lvl_a_i,
  input  logic           lvl_b_i,
  input  logic [WCW-1:0] word_count_i,
  output logic           word_valid_o,
  output logic [31:0]    word_data_o,
  output logic           frame_done_o,
  output logic           chk_err_o,
  output logic           frame_err_o
);
  localparam int BCW = WCW + 3;
  localparam int TW  = $clog2(TMO_CYC + 1);

  rx_state_e      state_q;
  logic           last_a_q;
  logic [2:0]     bit_cnt_q;
  logic [7:0]     shr_q;
  logic [BCW-1:0] byte_cnt_q;
  logic [31:0]    word_q;
  logic [7:0]     xor_q;
  logic           chk_seen_q, chk_bad_q;
  logic [WCW-1:0] nw_q;
  logic [2:0]     sync_cnt_q;
  logic [TW-1:0]  tmo_q;
  logic           valid_q, done_q, cerr_q, ferr_q;

  // Named events, used by the assertions.
  logic           any_fall, slot_a, slot_b, stop_ev, bit_ev, bit_val;
  logic           byte_ev, is_data, is_chk, tmo_hit, start_ev;
  logic [7:0]     byte_val;
  logic [BCW-1:0] n_data;

  always_comb begin
    any_fall = fall_a_i | fall_b_i;
    slot_a   = fall_a_i;
    slot_b   = fall_b_i & ~fall_a_i;
    stop_ev  = slot_a & last_a_q;
    bit_ev   = (slot_a & ~last_a_q) | (slot_b & last_a_q);
    bit_val  = slot_a ? lvl_b_i : lvl_a_i;
    byte_val = {shr_q[6:0], bit_val};
    byte_ev  = bit_ev & byte_last_bit(bit_cnt_q);
    n_data   = BCW'({nw_q, 2'b00});
    is_data  = byte_cnt_q < n_data;
    is_chk   = byte_cnt_q == n_data;
    tmo_hit  = !any_fall && (tmo_q == TW'(TMO_CYC - 1));
    start_ev = fall_b_i && !lvl_a_i && (sync_cnt_q == 3'd3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HUNT;
      last_a_q   <= 1'b0;
      bit_cnt_q  <= '0;
      shr_q      <= '0;
      byte_cnt_q <= '0;
      word_q     <= '0;
      xor_q      <= '0;
      chk_seen_q <= 1'b0;
      chk_bad_q  <= 1'b0;
      nw_q       <= '0;
      sync_cnt_q <= '0;
      tmo_q      <= '0;
      valid_q    <= 1'b0;
      done_q     <= 1'b0;
      cerr_q     <= 1'b0;
      ferr_q     <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      cerr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      if (state_q == ST_HUNT) begin
        nw_q  <= word_count_i;
        tmo_q <= '0;
        if (lvl_a_i)       sync_cnt_q <= '0;
        else if (fall_b_i) sync_cnt_q <= sync_cnt_q + 1'b1;
        if (start_ev) begin
          state_q    <= ST_RX;
          last_a_q   <= 1'b0;
          bit_cnt_q  <= '0;
          byte_cnt_q <= '0;
          xor_q      <= '0;
          chk_seen_q <= 1'b0;
          chk_bad_q  <= 1'b0;
          sync_cnt_q <= '0;
        end
      end else begin
        tmo_q <= any_fall ? '0 : tmo_q + 1'b1;
        if (tmo_hit) begin
          ferr_q  <= 1'b1;
          state_q <= ST_HUNT;
        end else if (stop_ev) begin
          state_q <= ST_HUNT;
          if (chk_seen_q) begin
            done_q <= 1'b1;
            cerr_q <= chk_bad_q;
          end else begin
            ferr_q <= 1'b1;
          end
        end else if (bit_ev) begin
          last_a_q  <= slot_a;
          shr_q     <= byte_val;
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (byte_ev) begin
            byte_cnt_q <= byte_cnt_q + 1'b1;
            if (is_data) begin
              xor_q  <= xor_q ^ byte_val;
              word_q <= push_byte(word_q, byte_val);
              if (byte_cnt_q[1:0] == 2'd3) valid_q <= 1'b1;
            end else if (is_chk) begin
              chk_seen_q <= 1'b1;
              chk_bad_q  <= (byte_val != xor_q);
            end else begin
              ferr_q  <= 1'b1;
              state_q <= ST_HUNT;
            end
          end
        end
      end
    end
  end

  assign word_valid_o = valid_q;
  assign word_data_o  = word_q;
  assign frame_done_o = done_q;
  assign chk_err_o    = cerr_q;
  assign frame_err_o  = ferr_q;

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done_o && frame_err_o));  // R8
  AST_CHKERR_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err_o |-> frame_done_o);  // R6
  AST_VALID_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> state_q == ST_RX);  // R4
  AST_DONE_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> state_q == ST_HUNT);  // R7
  AST_ERR_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> state_q == ST_HUNT);  // R10

endmodule

// File: rtl/ac2w_rx.sv
module ac2w_rx #(
  parameter int WCW      = 8,
  parameter int FILT_LEN = 3,
  parameter int TMO_CYC  = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_a_i,
  input  logic           line_b_i,
  input  logic [WCW-1:0] word_count_i,
  output logic           word_valid_o,
  output logic [31:0]    word_data_o,
  output logic           frame_done_o,
  output logic           chk_err_o,
  output logic           frame_err_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, lvl, fall;

  assign raw_lines = {line_b_i, line_a_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    ac2w_line_cond #(.FILT_LEN(FILT_LEN)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[i]),
      .level_o(lvl[i]),
      .fall_o (fall[i])
    );
  end

  ac2w_frame_fsm #(.WCW(WCW), .TMO_CYC(TMO_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_a_i    (fall[0]),
    .fall_b_i    (fall[1]),
    .lvl_a_i     (lvl[0]),
    .lvl_b_i     (lvl[1]),
    .word_count_i(word_count_i),
    .word_valid_o(word_valid_o),
    .word_data_o (word_data_o),
    .frame_done_o(frame_done_o),
    .chk_err_o   (chk_err_o),
    .frame_err_o (frame_err_o)
  );

endmodule

// File: tb/ac2w_rx_tb_top.sv
`timescale 1ns/1ps
module ac2w_rx_tb_top;
  localparam int WCW = 8;
  localparam int Q   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic la = 1'b1, lb = 1'b1;
  logic [WCW-1:0] wcount = '0;
  logic wvalid, fdone, cerr, ferr;
  logic [31:0] wdata;

  int n_checks = 0, n_fail = 0;
  int done_n = 0, cerr_n = 0, ferr_n = 0;
  bit ph_a = 1'b1;
  bit glitch_now = 1'b0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  ac2w_rx dut_i (
    .clk(clk), .rst_n(rst_n), .line_a_i(la), .line_b_i(lb),
    .word_count_i(wcount), .word_valid_o(wvalid), .word_data_o(wdata),
    .frame_done_o(fdone), .chk_err_o(cerr), .frame_err_o(ferr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as words appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wvalid) begin
        if (exp_q.size() == 0) check("R9 unexpected word", wdata, 32'hxxxx_xxxx);
        else check("R4 word", wdata, exp_q.pop_front());
      end
      if (fdone) done_n++;
      if (cerr)  cerr_n++;
      if (ferr)  ferr_n++;
    end
  end

  task automatic q_wait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_sync(int pulses);
    la = 1'b0; q_wait();
    for (int i = 0; i < pulses; i++) begin
      lb = 1'b0; q_wait();
      lb = 1'b1; q_wait();
    end
    la = 1'b1; q_wait();
    lb = 1'b0; q_wait();
    ph_a = 1'b1;
  endtask

  task automatic send_bit(logic v);
    if (ph_a) begin
      if (glitch_now) begin
        la = 1'b0; @(negedge clk); la = 1'b1; glitch_now = 1'b0;
      end
      lb = v;    q_wait();
      la = 1'b0; q_wait();
      lb = 1'b1; q_wait();
    end else begin
      la = v;    q_wait();
      lb = 1'b0; q_wait();
      la = 1'b1; q_wait();
    end
    ph_a = !ph_a;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  // Sends a word as four bytes, last byte first; returns their XOR.
  task automatic send_word(logic [31:0] w, bit expect_it, inout logic [7:0] acc);
    if (expect_it) exp_q.push_back(w);
    for (int k = 0; k < 4; k++) begin
      send_byte(w[8*k +: 8]);
      acc = acc ^ w[8*k +: 8];
    end
  endtask

  task automatic send_stop();
    lb = 1'b1; q_wait();
    lb = 1'b0; q_wait();
    la = 1'b0; q_wait();
    la = 1'b1; q_wait();
    la = 1'b0; q_wait();
    la = 1'b1; lb = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic snap(output int d, output int c, output int f);
    d = done_n; c = cerr_n; f = ferr_n;
  endtask

  task automatic expect_ev(string req, int d0, int c0, int f0, int d, int c, int f);
    check({req, " done"},  done_n - d0, d);
    check({req, " cerr"},  cerr_n - c0, c);
    check({req, " ferr"},  ferr_n - f0, f);
    check({req, " words left"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int d0, c0, f0;
    logic [7:0] acc;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 valid", wvalid, 0);
    check("R1 done",  fdone, 0);
    check("R1 cerr",  cerr, 0);
    check("R1 ferr",  ferr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R4 R5 R7: good two-word frame with a known byte-order vector
    wcount = 8'd2; snap(d0, c0, f0); acc = '0;
    do_sync(4);
    send_word(32'h0102_0304, 1, acc);
    send_word(32'hA5C3_0FF0, 1, acc);
    send_byte(acc); send_stop();
    expect_ev("R5", d0, c0, f0, 1, 0, 0);

    // R6 bad checksum
    wcount = 8'd1; snap(d0, c0, f0); acc = '0;
    do_sync(4);
    send_word(32'hDEAD_BEEF, 1, acc);
    send_byte(acc ^ 8'h01); send_stop();
    expect_ev("R6", d0, c0, f0, 1, 1, 0);

    // R2 three-edge start pattern is not a start
    wcount = 8'd1; snap(d0, c0, f0); acc = '0;
    do_sync(3);
    send_word(32'h1111_2222, 0, acc);
    send_byte(acc); send_stop();
    expect_ev("R2", d0, c0, f0, 0, 0, 0);

    // R8 stop before checksum
    wcount = 8'd2; snap(d0, c0, f0); acc = '0;
    do_sync(4);
    send_word(32'h7654_3210, 1, acc);
    send_stop();
    expect_ev("R8", d0, c0, f0, 0, 0, 1);

    // R9 surplus word
    wcount = 8'd1; snap(d0, c0, f0); acc = '0;
    do_sync(4);
    send_word(32'h0BAD_F00D, 1, acc);
    send_word(32'h5555_AAAA, 0, acc);
    send_byte(acc); send_stop();
    expect_ev("R9", d0, c0, f0, 0, 0, 1);

    // R10 timeout mid-frame, then recovery
    wcount = 8'd1; snap(d0, c0, f0);
    do_sync(4);
    send_byte(8'h12); send_byte(8'h34);
    repeat (300) @(negedge clk);
    la = 1'b1; lb = 1'b1;
    repeat (20) @(negedge clk);
    expect_ev("R10 timeout", d0, c0, f0, 0, 0, 1);
    snap(d0, c0, f0); acc = '0;
    do_sync(4);
    send_word(32'hCAFE_0001, 1, acc);
    send_byte(acc); send_stop();
    expect_ev("R10 recovery", d0, c0, f0, 1, 0, 0);

    // R11 short glitch on line A inside a frame
    wcount = 8'd1; snap(d0, c0, f0); acc = '0;
    do_sync(4);
    send_bit(1'b1);
    glitch_now = 1'b1;
    send_bit(1'b0); send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    exp_q.push_back(32'h3C3C_3CA6);
    acc = 8'hA6;
    send_byte(8'h3C); send_byte(8'h3C); send_byte(8'h3C);
    acc = acc ^ 8'h3C ^ 8'h3C ^ 8'h3C;
    send_byte(acc); send_stop();
    expect_ev("R11", d0, c0, f0, 1, 0, 0);

    // R12 zero-word frame
    wcount = 8'd0; snap(d0, c0, f0);
    do_sync(4);
    send_byte(8'h00); send_stop();
    expect_ev("R12", d0, c0, f0, 1, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule